// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words in the standard single format: 1 sign bit, 8 exponent bits with bias 127, and 23 fraction bits. A one-cycle `start_i` pulse loads both operands and the operation. Setting `sub_i` computes a minus b by inverting the sign of b. The result is rounded to nearest with ties to even. Five exception flags come with it.

The unit works on one operation at a time. When either operand is a NaN or an infinity, or both operands are zeros, the sum needs no arithmetic: the result comes back after one clock. All other operands go through alignment with guard, round and sticky bits, the integer add, normalization and rounding, and the result comes back after two clocks. `ready_o` pulses for one cycle with the result. `result_o` and `flags_o` then hold until the next pulse.

Top module: `fp_addsub`

## Requirements
- R1: While reset is held and after it is released, `ready_o`, `result_o` and `flags_o` are all zero.
- R2: `start_i` is accepted only when the unit is idle. A start raised while an operation is in flight is ignored and produces no extra `ready_o` pulse. When `sub_i` is 1, the sign of b is inverted.
- R3: `ready_o` rises exactly 2 clocks after the accepting edge for a computed sum, and 1 clock after it when an operand is a NaN or an infinity or both operands are zeros. It stays high for one cycle. `result_o` and `flags_o` hold between pulses.
- R4: A finite result equals the exact sum rounded to nearest, with ties to even. Bits shifted out while aligning the smaller operand still decide the rounding.
- R5: A NaN operand gives the quiet NaN 0x7FC00000. Invalid (flag bit 4) is set only when a NaN operand is signalling, meaning its exponent is all ones, its fraction is nonzero and fraction bit 22 is 0.
- R6: Infinities of opposite effective sign give 0x7FC00000 with invalid set. An infinity combined with any finite value gives that infinity, with no flags.
- R7: An exact zero sum from operands of opposite effective sign is +0. Two zeros of the same effective sign keep that sign, so -0 + -0 is -0 and -0 minus +0 is -0.
- R8: If the rounded exponent reaches 255, the result is the infinity of the result's sign, with overflow (bit 2) and inexact (bit 0) set.
- R9: Subnormal operands are accepted, and subnormal or minimum-normal results are formed exactly. Underflow (bit 1) is set only for a result that is tiny before rounding and inexact, and for a sum this case cannot occur.
- R10: Inexact (bit 0) is set exactly when the rounded result differs from the exact sum. Divide-by-zero (bit 3) is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the operands and begin, honoured when idle |
| sub_i | input | 1 | 1 selects a minus b, 0 selects a plus b |
| a_i | input | 32 | Operand a, single format |
| b_i | input | 32 | Operand b, single format |
| ready_o | output | 1 | One-cycle pulse, result and flags valid |
| result_o | output | 32 | Rounded result |
| flags_o | output | 5 | {invalid, div-by-zero, overflow, underflow, inexact} |

## Verification
A wrong alignment shift or a lost sticky bit shows on the very next `ready_o` pulse. It appears as a last-place error, or as a tie broken the wrong way, in vectors chosen to land exactly on, just above and just below a halfway point. A corrupted state register shows as a pulse one cycle early or late, a second pulse, or an accepted start during a busy cycle. Latency is measured for every result, so any of these faults is caught at the first operation. A wrong special-case decode shows as a wrong NaN or infinity pattern or a wrong invalid bit, within one clock of the start.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_ROUND} fsm_e;
  localparam int FLG_W   = 5;
  localparam int FLG_INV = 4;
  localparam int FLG_DZ  = 3;
  localparam int FLG_OVF = 2;
  localparam int FLG_UNF = 1;
  localparam int FLG_NX  = 0;
  localparam int GRS_W   = 3;
endpackage

// File: rtl/fp_unpack.sv
module fp_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op_i,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W:0]       sig_o,
  output logic                 zero_o,
  output logic                 inf_o,
  output logic                 nan_o,
  output logic                 snan_o
);
  logic [EXP_W-1:0] e_raw;
  logic [MAN_W-1:0] frac;
  logic e_one, e_zero, f_zero;

  assign sign_o = op_i[EXP_W+MAN_W];
  assign e_raw  = op_i[EXP_W+MAN_W-1:MAN_W];
  assign frac   = op_i[MAN_W-1:0];
  assign e_one  = &e_raw;
  assign e_zero = ~|e_raw;
  assign f_zero = ~|frac;
  // subnormals share the scale of exponent 1
  assign exp_o  = e_zero ? EXP_W'(1) : e_raw;
  assign sig_o  = {~e_zero, frac};
  assign zero_o = e_zero & f_zero;
  assign inf_o  = e_one & f_zero;
  assign nan_o  = e_one & ~f_zero;
  assign snan_o = nan_o & ~frac[MAN_W-1];
endmodule

// File: rtl/fp_align_add.sv
module fp_align_add
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int EXT_W = SIG_W + GRS_W,
  localparam int SUM_W = EXT_W + 1
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             sa_i,
  input  logic             sb_i,
  input  logic [EXP_W-1:0] ea_i,
  input  logic [EXP_W-1:0] eb_i,
  input  logic [MAN_W:0]   siga_i,
  input  logic [MAN_W:0]   sigb_i,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SUM_W-1:0] sum_o
);
  logic             a_big, s_big;
  logic [EXP_W-1:0] e_big, e_sml, diff;
  logic [EXT_W-1:0] x_big, x_sml, al;
  logic             st;

  assign a_big = a_i[W-2:0] >= b_i[W-2:0];

  always_comb begin
    s_big = a_big ? sa_i : sb_i;
    e_big = a_big ? ea_i : eb_i;
    e_sml = a_big ? eb_i : ea_i;
    x_big = {(a_big ? siga_i : sigb_i), GRS_W'(0)};
    x_sml = {(a_big ? sigb_i : siga_i), GRS_W'(0)};
    diff  = e_big - e_sml;
    if (diff >= EXP_W'(EXT_W)) begin
      al = '0;
      st = |x_sml;
    end else begin
      al = x_sml >> diff;
      st = |(x_sml & ~({EXT_W{1'b1}} << diff));
    end
    al[0] = al[0] | st;
    if (sa_i ^ sb_i) sum_o = {1'b0, x_big} - {1'b0, al};
    else             sum_o = {1'b0, x_big} + {1'b0, al};
    // exact cancellation gives +0
    sign_o = (sum_o == '0) ? 1'b0 : s_big;
    exp_o  = e_big;
  end
endmodule

// File: rtl/fp_norm_round.sv
module fp_norm_round
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int EXT_W = SIG_W + GRS_W,
  localparam int SUM_W = EXT_W + 1,
  localparam int E_W   = EXP_W + 2,
  localparam int E_MAX = (1 << EXP_W) - 1
) (
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [W-1:0]     res_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             nx_o
);
  logic [E_W-1:0]   e, lz, lim, sh;
  logic [EXT_W-1:0] n;
  logic [SIG_W-1:0] mant;
  logic [SIG_W:0]   m;
  logic             up, tiny;

  always_comb begin
    e  = {2'b00, exp_i};
    lz = E_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (sum_i[i]) lz = E_W'(EXT_W - 1 - i);
    lim = e - E_W'(1);
    sh  = '0;
    if (sum_i[SUM_W-1]) begin
      n    = sum_i[SUM_W-1:1];
      n[0] = n[0] | sum_i[0];
      e    = e + E_W'(1);
    end else begin
      // left shift stops at the subnormal boundary
      sh = (lz < lim) ? lz : lim;
      n  = sum_i[EXT_W-1:0] << sh;
      e  = e - sh;
    end
    tiny = ~n[EXT_W-1];
    mant = n[EXT_W-1:GRS_W];
    nx_o = |n[GRS_W-1:0];
    up   = n[GRS_W-1] & ((|n[GRS_W-2:0]) | mant[0]);
    m    = {1'b0, mant} + (SIG_W+1)'(up);
    if (m[SIG_W]) begin
      m = m >> 1;
      e = e + E_W'(1);
    end
    ovf_o = e >= E_W'(E_MAX);
    if (ovf_o) begin
      res_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      nx_o  = 1'b1;
    end else begin
      res_o = {sign_i, (m[SIG_W-1] ? e[EXP_W-1:0] : {EXP_W{1'b0}}), m[MAN_W-1:0]};
    end
    unf_o = tiny & nx_o & ~ovf_o;
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SUM_W = MAN_W + 1 + GRS_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic             ready_o,
  output logic [W-1:0]     result_o,
  output logic [FLG_W-1:0] flags_o
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  fsm_e             state_q;
  logic [W-1:0]     ops [2];
  logic             sgn [2], zro [2], inf [2], nan [2], snan [2];
  logic [EXP_W-1:0] ex  [2];
  logic [MAN_W:0]   sig [2];

  logic             add_sign, sum_sign_q;
  logic [EXP_W-1:0] add_exp, sum_exp_q;
  logic [SUM_W-1:0] add_sum, sum_q;
  logic [W-1:0]     rnd_res, spc_res;
  logic             rnd_ovf, rnd_unf, rnd_nx;
  logic             spc, spc_inv, inf_clash;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    fp_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp (
      .op_i(ops[g]), .sign_o(sgn[g]), .exp_o(ex[g]), .sig_o(sig[g]),
      .zero_o(zro[g]), .inf_o(inf[g]), .nan_o(nan[g]), .snan_o(snan[g]));
  end

  fp_align_add #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_add (
    .a_i(ops[0]), .b_i(ops[1]), .sa_i(sgn[0]), .sb_i(sgn[1]),
    .ea_i(ex[0]), .eb_i(ex[1]), .siga_i(sig[0]), .sigb_i(sig[1]),
    .sign_o(add_sign), .exp_o(add_exp), .sum_o(add_sum));

  fp_norm_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rnd (
    .sign_i(sum_sign_q), .exp_i(sum_exp_q), .sum_i(sum_q),
    .res_o(rnd_res), .ovf_o(rnd_ovf), .unf_o(rnd_unf), .nx_o(rnd_nx));

  always_comb begin
    inf_clash = inf[0] & inf[1] & (sgn[0] ^ sgn[1]);
    spc       = nan[0] | nan[1] | inf[0] | inf[1] | (zro[0] & zro[1]);
    spc_inv   = snan[0] | snan[1] | (inf_clash & ~nan[0] & ~nan[1]);
    if (nan[0] | nan[1] | inf_clash) spc_res = QNAN;
    else if (inf[0])                 spc_res = {sgn[0], {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (inf[1])                 spc_res = {sgn[1], {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else                             spc_res = {sgn[0] & sgn[1], {(W-1){1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ops[0]     <= '0;
      ops[1]     <= '0;
      sum_sign_q <= 1'b0;
      sum_exp_q  <= '0;
      sum_q      <= '0;
      ready_o    <= 1'b0;
      result_o   <= '0;
      flags_o    <= '0;
    end else begin
      ready_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ops[0]  <= a_i;
          ops[1]  <= {b_i[W-1] ^ sub_i, b_i[W-2:0]};
          state_q <= ST_EVAL;
        end
        ST_EVAL: if (spc) begin
          result_o         <= spc_res;
          flags_o          <= '0;
          flags_o[FLG_INV] <= spc_inv;
          ready_o          <= 1'b1;
          state_q          <= ST_IDLE;
        end else begin
          sum_sign_q <= add_sign;
          sum_exp_q  <= add_exp;
          sum_q      <= add_sum;
          state_q    <= ST_ROUND;
        end
        ST_ROUND: begin
          result_o <= rnd_res;
          flags_o  <= {1'b0, 1'b0, rnd_ovf, rnd_unf, rnd_nx};
          ready_o  <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input fsm_e             state_q,
  input logic             ready_o,
  input logic [W-1:0]     result_o,
  input logic [FLG_W-1:0] flags_o
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  assert_ready_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_hold_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> ($stable(result_o) && $stable(flags_o)));
  assert_ready_from_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ($past(state_q) != ST_IDLE && state_q == ST_IDLE));
  assert_no_divzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !flags_o[FLG_DZ]);
  assert_overflow_inf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && flags_o[FLG_OVF]) |->
      (flags_o[FLG_NX] && result_o[W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}));
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !flags_o[FLG_UNF]);
  assert_invalid_nan_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && flags_o[FLG_INV]) |-> (result_o == QNAN));
endmodule

bind fp_addsub fp_addsub_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_q(state_q), .ready_o(ready_o),
  .result_o(result_o), .flags_o(flags_o));

// File: tb/fp_addsub_bench.sv
module fp_addsub_bench;
  typedef struct {
    logic [31:0] res;
    logic [4:0]  flg;
    int          lat;
    int          issue;
    string       tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        ready_o;
  logic [31:0] result_o;
  logic [4:0]  flags_o;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  item_t q[$];

  localparam logic [4:0] F0 = 5'h00, FNX = 5'h01, FOV = 5'h05, FINV = 5'h10;

  fp_addsub u_fp_addsub (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // monitor: pops one expected item per ready pulse
  always @(negedge clk_i) begin
    if (rst_ni && ready_o) begin
      if (q.size() == 0) begin
        chk("R2 unexpected ready", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk({it.tag, " result"}, result_o, it.res);
        chk({it.tag, " flags"}, {27'd0, flags_o}, {27'd0, it.flg});
        chk({it.tag, " R3 latency"}, cyc - it.issue - 1, it.lat);
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       input logic [31:0] res, input logic [4:0] flg, input int lat,
                       input string tag);
    item_t it;
    @(negedge clk_i);
    a_i = a; b_i = b; sub_i = sub; start_i = 1'b1;
    it.res = res; it.flg = flg; it.lat = lat; it.issue = cyc; it.tag = tag;
    q.push_back(it);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic sub,
                     input logic [31:0] res, input logic [4:0] flg, input int lat,
                     input string tag);
    issue(a, b, sub, res, flg, lat, tag);
    wait (q.size() == 0);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 ready in reset", {31'd0, ready_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready", {31'd0, ready_o}, 32'd0);
    chk("R1 result", result_o, 32'd0);
    chk("R1 flags", {27'd0, flags_o}, 32'd0);

    run(32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, F0, 2, "R4 1+2");
    run(32'h3FC00000, 32'h3FA00000, 1'b1, 32'h3E800000, F0, 2, "R4 R2 cancel sub");
    run(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, FNX, 2, "R4 tie even down");
    run(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, FNX, 2, "R4 tie even up");
    run(32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, FNX, 2, "R4 sticky above tie");
    run(32'h3F800000, 32'h33800000, 1'b1, 32'h3F7FFFFF, F0, 2, "R4 R10 exact borrow");
    run(32'h3F800000, 32'h33000000, 1'b1, 32'h3F800000, FNX, 2, "R4 borrow tie");
    run(32'h3F800000, 32'h0D800000, 1'b0, 32'h3F800000, FNX, 2, "R10 far operand");
    run(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, F0, 2, "R7 x-x");
    run(32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, F0, 2, "R7 -x+x");
    run(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, F0, 1, "R7 -0+-0");
    run(32'h80000000, 32'h00000000, 1'b1, 32'h80000000, F0, 1, "R7 -0 minus +0");
    run(32'h7FC00000, 32'h3F800000, 1'b0, 32'h7FC00000, F0, 1, "R5 quiet nan");
    run(32'h3F800000, 32'h7F800001, 1'b0, 32'h7FC00000, FINV, 1, "R5 signalling nan");
    run(32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, FINV, 1, "R6 inf clash add");
    run(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, FINV, 1, "R6 inf clash sub");
    run(32'hFF800000, 32'h3F800000, 1'b0, 32'hFF800000, F0, 1, "R6 inf plus finite");
    run(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, FOV, 2, "R8 overflow pos");
    run(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, FOV, 2, "R8 overflow neg");
    run(32'h00000001, 32'h00000001, 1'b0, 32'h00000002, F0, 2, "R9 subnormal add");
    run(32'h00400000, 32'h00400000, 1'b0, 32'h00800000, F0, 2, "R9 to min normal");
    run(32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF, F0, 2, "R9 to subnormal");

    // R2: a start held during the busy cycle must be ignored
    issue(32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, F0, 2, "R2 busy first");
    a_i = 32'h40000000; b_i = 32'h40000000; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait (q.size() == 0);
    repeat (4) @(negedge clk_i);
    chk("R2 R3 held result after ignored start", result_o, 32'h40400000);
    chk("R2 no second pulse", {31'd0, ready_o}, 32'd0);
    run(32'h40000000, 32'h40000000, 1'b0, 32'h40800000, F0, 2, "R2 next start");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule